// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from three kinds of source and presents the single most urgent one to a processor core as a vector address. One emulator request sits above everything and cannot be masked. Four fixed core sources occupy the top four positions of a 16-bit pending register. A parameterized set of peripheral sources is routed onto the twelve remaining user positions through a per-peripheral 4-bit slot field that software may rewrite at any time. A slot field value of 12 or more leaves that peripheral unable to interrupt.

Each request is captured on its rising edge into the pending register. A pending bit takes part in selection only if its enable bit is set and the global enable is on. The two highest core positions ignore the global enable. The winner is the lowest pending, enabled index. It is offered only when it outranks the source currently being served. The vector is the slot index times 0x20, added to a base of 0 or 0x10000; the base is chosen by a boot-mode input. An acknowledge takes the offered source, clears its pending bit, records it as in service and freezes the vector until the acknowledge drops. A separate end-of-service pulse clears the in-service record. Nested levels are not kept.

Top module: `irqDispatcher`

## Requirements
- R1: After reset the pending register and the enable register read zero, no interrupt is offered, nothing is in service, and peripheral n has slot field value n.
- R2: A core request input sets pending bit k (k = 0..3, input bit k) on the first clock edge at which it is sampled high after being low. Holding it high does not set the bit again after it is cleared.
- R3: A peripheral rising edge sets pending bit 4+v, where v is the peripheral's slot field. Values 12..15 set no bit.
- R4: Writing the slot field of a peripheral ID changes the bit that its later edges set. Peripherals that share a slot value feed the same pending bit.
- R5: The offered source is the lowest-index bit that is pending and enabled. When the global enable is low, only bits 0 and 1 can be offered.
- R6: For an offered slot s, the vector is base + 0x20*s on 24 bits. The base is 0x10000 when the boot-mode input is high and 0 when it is low.
- R7: A rising edge on the emulator request is offered ahead of every slot, regardless of masking or the global enable. It is flagged on the emulator output and has vector 0.
- R8: Acknowledge while an interrupt is offered clears that source's pending state at the same edge and withdraws the offer. The vector, slot and emulator flag then hold their values, whatever the boot-mode input does, until acknowledge is low.
- R9: While a slot is in service, slots of equal or lower priority are not offered and higher slots are. While the emulator request is in service nothing is offered. An end-of-service pulse clears the record.
- R10: The enable register is loaded whole by a write strobe, and a pending bit whose enable bit is clear is never offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| emuReq | input | 1 | Emulator request, edge captured |
| coreReq | input | 4 | Fixed core requests, bit k maps to pending bit k |
| periphReq | input | NUM_PERIPH | Peripheral requests, edge captured |
| prioWrEn | input | 1 | Slot field write strobe |
| prioWrId | input | ID_W | Peripheral ID whose slot field is written |
| prioWrVal | input | PRIO_W | New slot value |
| maskWrEn | input | 1 | Enable register write strobe |
| maskWrData | input | 16 | New enable register value |
| globalEn | input | 1 | Global interrupt enable |
| noBootExt | input | 1 | Selects vector base 0x10000 |
| intAck | input | 1 | Acknowledge from the core |
| svcDone | input | 1 | End-of-service pulse |
| intReq | output | 1 | Interrupt offered |
| intEmu | output | 1 | Offered or held source is the emulator request |
| intSlot | output | 4 | Offered or held slot index |
| intVector | output | VEC_W | Offered or held vector address |
| latchOut | output | 16 | Pending register |
| maskOut | output | 16 | Enable register |

## Verification
A request level sampled high at clock edge N shows in the pending register right after edge N. The offer, slot and vector follow combinationally in that same cycle, so every check samples on the falling edge one rising edge after the input was driven. Acknowledge, enable writes and end-of-service each take effect at the single rising edge at which they are sampled. A boot-mode or global-enable change alters the live vector without any edge. The bench drives all inputs on falling edges and checks on the next falling edge. It holds acknowledge across a boot-mode change to show the frozen vector. A bench model of pending bits, enables and slot fields predicts each offer during the random phase.

// File: rtl/irqDispPkg.sv
package irqDispPkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic take;      // offered source accepted this edge
    logic showHeld;  // drive outputs from the frozen copy
  } ctrlStrobes_t;
endpackage

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqDispPkg::*;
#(
  parameter int NUM_PERIPH   = 8,
  parameter int SLOTS        = 16,
  parameter int CORE_SLOTS   = 4,
  parameter int PRIO_W       = 4,
  parameter int VEC_W        = 24,
  parameter int VEC_STRIDE   = 32,
  parameter int EXT_BASE     = 'h10000,
  parameter int NOGATE_SLOTS = 2,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int ID_W   = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  emuReq,
  input  logic [CORE_SLOTS-1:0] coreReq,
  input  logic [NUM_PERIPH-1:0] periphReq,
  input  logic                  prioWrEn,
  input  logic [ID_W-1:0]       prioWrId,
  input  logic [PRIO_W-1:0]     prioWrVal,
  input  logic                  maskWrEn,
  input  logic [SLOTS-1:0]      maskWrData,
  input  logic                  globalEn,
  input  logic                  noBootExt,
  input  ctrlStrobes_t          strb,
  output logic                  selValid,
  output logic                  selEmu,
  output logic [SLOT_W-1:0]     selSlot,
  output logic                  outEmu,
  output logic [SLOT_W-1:0]     outSlot,
  output logic [VEC_W-1:0]      outVector,
  output logic [SLOTS-1:0]      latchQ,
  output logic [SLOTS-1:0]      maskQ
);
  localparam int USER_SLOTS = SLOTS - CORE_SLOTS;
  localparam int STRIDE_SH  = $clog2(VEC_STRIDE);
  localparam logic [SLOTS-1:0] NOGATE = SLOTS'((1 << NOGATE_SLOTS) - 1);

  // Edge detection
  logic                  emuPrev;
  logic [CORE_SLOTS-1:0] corePrev;
  logic [NUM_PERIPH-1:0] perPrev;
  logic                  emuEdge;
  logic [CORE_SLOTS-1:0] coreEdge;
  logic [NUM_PERIPH-1:0] perEdge;

  assign emuEdge  = emuReq & ~emuPrev;
  assign coreEdge = coreReq & ~corePrev;
  assign perEdge  = periphReq & ~perPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      emuPrev  <= 1'b0;
      corePrev <= '0;
      perPrev  <= '0;
    end else begin
      emuPrev  <= emuReq;
      corePrev <= coreReq;
      perPrev  <= periphReq;
    end
  end

  // Per-peripheral slot fields
  logic [PRIO_W-1:0] prioQ [NUM_PERIPH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PERIPH; i++) prioQ[i] <= PRIO_W'(i % USER_SLOTS);
    end else if (prioWrEn) begin
      prioQ[prioWrId] <= prioWrVal;
    end
  end

  // Map each peripheral edge onto a one-hot pending position
  logic [SLOTS-1:0] perHot [NUM_PERIPH];

  for (genvar g = 0; g < NUM_PERIPH; g++) begin : gMap
    logic [SLOT_W:0] tgt;
    logic            inRange;
    assign tgt     = (SLOT_W+1)'(CORE_SLOTS) + (SLOT_W+1)'(prioQ[g]);
    assign inRange = (prioQ[g] < PRIO_W'(USER_SLOTS));
    assign perHot[g] = (perEdge[g] && inRange) ? (SLOTS'(1) << tgt) : '0;
  end

  logic [SLOTS-1:0] setVec;
  logic [SLOTS-1:0] clrVec;

  always_comb begin
    setVec = '0;
    setVec[CORE_SLOTS-1:0] = coreEdge;
    for (int i = 0; i < NUM_PERIPH; i++) setVec = setVec | perHot[i];
  end

  assign clrVec = (strb.take && !selEmu) ? (SLOTS'(1) << selSlot) : '0;

  // Pending, enable and emulator state
  logic emuPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ  <= '0;
      maskQ   <= '0;
      emuPend <= 1'b0;
    end else begin
      latchQ <= (latchQ & ~clrVec) | setVec;
      if (maskWrEn) maskQ <= maskWrData;
      if (emuEdge) emuPend <= 1'b1;
      else if (strb.take && selEmu) emuPend <= 1'b0;
    end
  end

  // Priority selection: lowest index wins
  logic [SLOTS-1:0]  eligible;
  logic              foundAny;
  logic [SLOT_W-1:0] pickSlot;

  assign eligible = latchQ & maskQ & (globalEn ? {SLOTS{1'b1}} : NOGATE);

  always_comb begin
    foundAny = 1'b0;
    pickSlot = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        foundAny = 1'b1;
        pickSlot = SLOT_W'(i);
      end
    end
  end

  assign selEmu   = emuPend;
  assign selValid = emuPend | foundAny;
  assign selSlot  = emuPend ? '0 : pickSlot;

  // Vector formation
  logic [VEC_W-1:0] baseAddr;
  logic [VEC_W-1:0] liveVec;

  assign baseAddr = noBootExt ? VEC_W'(EXT_BASE) : '0;
  assign liveVec  = selEmu ? '0 : baseAddr + (VEC_W'(selSlot) << STRIDE_SH);

  // Frozen copy for the acknowledge window
  logic              heldEmu;
  logic [SLOT_W-1:0] heldSlot;
  logic [VEC_W-1:0]  heldVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldEmu  <= 1'b0;
      heldSlot <= '0;
      heldVec  <= '0;
    end else if (strb.take) begin
      heldEmu  <= selEmu;
      heldSlot <= selSlot;
      heldVec  <= liveVec;
    end
  end

  assign outEmu    = strb.showHeld ? heldEmu  : selEmu;
  assign outSlot   = strb.showHeld ? heldSlot : selSlot;
  assign outVector = strb.showHeld ? heldVec  : liveVec;
endmodule

// File: rtl/irqControl.sv
module irqControl
  import irqDispPkg::*;
#(
  parameter int SLOTS = 16,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selValid,
  input  logic              selEmu,
  input  logic [SLOT_W-1:0] selSlot,
  input  logic              intAck,
  input  logic              svcDone,
  output logic              present,
  output ctrlStrobes_t      strb
);
  logic              holdQ;
  logic              svcValidQ;
  logic              svcEmuQ;
  logic [SLOT_W-1:0] svcSlotQ;
  logic              outranks;

  // The emulator outranks any slot; a slot must beat the one in service
  assign outranks = selEmu ? !svcEmuQ
                           : (!svcEmuQ && (!svcValidQ || (selSlot < svcSlotQ)));
  assign present  = !holdQ && selValid && outranks;

  assign strb.take     = present && intAck;
  assign strb.showHeld = holdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ     <= 1'b0;
      svcValidQ <= 1'b0;
      svcEmuQ   <= 1'b0;
      svcSlotQ  <= '0;
    end else begin
      if (strb.take)   holdQ <= 1'b1;
      else if (!intAck) holdQ <= 1'b0;

      if (strb.take) begin
        svcValidQ <= 1'b1;
        svcEmuQ   <= selEmu;
        svcSlotQ  <= selSlot;
      end else if (svcDone) begin
        svcValidQ <= 1'b0;
        svcEmuQ   <= 1'b0;
        svcSlotQ  <= '0;
      end
    end
  end
endmodule

// File: rtl/irqDispatcher.sv
module irqDispatcher
  import irqDispPkg::*;
#(
  parameter int NUM_PERIPH = 8,
  parameter int PRIO_W     = 4,
  parameter int VEC_W      = 24,
  localparam int SLOTS      = 16,
  localparam int CORE_SLOTS = 4,
  localparam int SLOT_W     = $clog2(SLOTS),
  localparam int ID_W       = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  emuReq,
  input  logic [CORE_SLOTS-1:0] coreReq,
  input  logic [NUM_PERIPH-1:0] periphReq,
  input  logic                  prioWrEn,
  input  logic [ID_W-1:0]       prioWrId,
  input  logic [PRIO_W-1:0]     prioWrVal,
  input  logic                  maskWrEn,
  input  logic [SLOTS-1:0]      maskWrData,
  input  logic                  globalEn,
  input  logic                  noBootExt,
  input  logic                  intAck,
  input  logic                  svcDone,
  output logic                  intReq,
  output logic                  intEmu,
  output logic [SLOT_W-1:0]     intSlot,
  output logic [VEC_W-1:0]      intVector,
  output logic [SLOTS-1:0]      latchOut,
  output logic [SLOTS-1:0]      maskOut
);
  ctrlStrobes_t      strb;
  logic              selValid;
  logic              selEmu;
  logic [SLOT_W-1:0] selSlot;

  irqDatapath #(
    .NUM_PERIPH(NUM_PERIPH), .SLOTS(SLOTS), .CORE_SLOTS(CORE_SLOTS),
    .PRIO_W(PRIO_W), .VEC_W(VEC_W), .VEC_STRIDE(32), .EXT_BASE('h10000),
    .NOGATE_SLOTS(2)
  ) uData (
    .clk(clk), .rstN(rstN), .emuReq(emuReq), .coreReq(coreReq),
    .periphReq(periphReq), .prioWrEn(prioWrEn), .prioWrId(prioWrId),
    .prioWrVal(prioWrVal), .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .globalEn(globalEn), .noBootExt(noBootExt), .strb(strb),
    .selValid(selValid), .selEmu(selEmu), .selSlot(selSlot),
    .outEmu(intEmu), .outSlot(intSlot), .outVector(intVector),
    .latchQ(latchOut), .maskQ(maskOut)
  );

  irqControl #(.SLOTS(SLOTS)) uCtrl (
    .clk(clk), .rstN(rstN), .selValid(selValid), .selEmu(selEmu),
    .selSlot(selSlot), .intAck(intAck), .svcDone(svcDone),
    .present(intReq), .strb(strb)
  );
endmodule

// File: rtl/irqDispatcherChk.sv
module irqDispatcherChk #(
  parameter int SLOTS        = 16,
  parameter int VEC_W        = 24,
  parameter int EXT_BASE     = 'h10000,
  parameter int STRIDE_SH    = 5,
  parameter int NOGATE_SLOTS = 2,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              globalEn,
  input logic              noBootExt,
  input logic              intAck,
  input logic              intReq,
  input logic              intEmu,
  input logic [SLOT_W-1:0] intSlot,
  input logic [VEC_W-1:0]  intVector,
  input logic [SLOTS-1:0]  latchOut,
  input logic [SLOTS-1:0]  maskOut
);
  // Checker-side record of the acknowledge window
  logic             heldActive;
  logic [VEC_W-1:0] heldSnap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldActive <= 1'b0;
      heldSnap   <= '0;
    end else if (intReq && intAck) begin
      heldActive <= 1'b1;
      heldSnap   <= intVector;
    end else if (!intAck) begin
      heldActive <= 1'b0;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (latchOut == '0 && maskOut == '0 && !intReq));

  p_offer_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && !intEmu) |-> (latchOut[intSlot] && maskOut[intSlot]));

  p_gate_bypass_r5: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && !intEmu && !globalEn) |-> (intSlot < SLOT_W'(NOGATE_SLOTS)));

  p_vector_r6: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && !intEmu) |->
      (intVector == ((noBootExt ? VEC_W'(EXT_BASE) : VEC_W'(0)) +
                     (VEC_W'(intSlot) << STRIDE_SH))));

  p_emu_vector_r7: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && intEmu) |-> (intVector == '0));

  p_take_withdraw_r8: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && intAck) |=> (!intReq && $stable(intVector)));

  p_hold_vector_r8: assert property (@(posedge clk) disable iff (!rstN)
    (heldActive && intAck) |-> (!intReq && intVector == heldSnap));
endmodule

bind irqDispatcher irqDispatcherChk #(
  .SLOTS(SLOTS), .VEC_W(VEC_W), .EXT_BASE('h10000), .STRIDE_SH(5), .NOGATE_SLOTS(2)
) uChk (
  .clk(clk), .rstN(rstN), .globalEn(globalEn), .noBootExt(noBootExt),
  .intAck(intAck), .intReq(intReq), .intEmu(intEmu), .intSlot(intSlot),
  .intVector(intVector), .latchOut(latchOut), .maskOut(maskOut)
);

// File: tb/tb_irqDispatcher.sv
module tb_irqDispatcher;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic        emuReq;
  logic [3:0]  coreReq;
  logic [NP-1:0] periphReq;
  logic        prioWrEn;
  logic [2:0]  prioWrId;
  logic [3:0]  prioWrVal;
  logic        maskWrEn;
  logic [15:0] maskWrData;
  logic        globalEn;
  logic        noBootExt;
  logic        intAck;
  logic        svcDone;
  logic        intReq;
  logic        intEmu;
  logic [3:0]  intSlot;
  logic [23:0] intVector;
  logic [15:0] latchOut;
  logic [15:0] maskOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Bench model
  logic [15:0] mLatch;
  logic [15:0] mMask;
  logic [3:0]  mPrio [NP];

  always #4 clk = ~clk;

  irqDispatcher #(.NUM_PERIPH(NP)) dut (
    .clk(clk), .rstN(rstN), .emuReq(emuReq), .coreReq(coreReq),
    .periphReq(periphReq), .prioWrEn(prioWrEn), .prioWrId(prioWrId),
    .prioWrVal(prioWrVal), .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .globalEn(globalEn), .noBootExt(noBootExt), .intAck(intAck),
    .svcDone(svcDone), .intReq(intReq), .intEmu(intEmu), .intSlot(intSlot),
    .intVector(intVector), .latchOut(latchOut), .maskOut(maskOut)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [23:0] expVec(input logic [3:0] s, input logic nb);
    return (nb ? 24'h010000 : 24'h0) + {15'd0, s, 5'd0};
  endfunction

  function automatic int expPick(input logic [15:0] lat, input logic [15:0] msk,
                                 input logic ge);
    logic [15:0] e;
    e = lat & msk & (ge ? 16'hFFFF : 16'h0003);
    for (int i = 0; i < 16; i++) if (e[i]) return i;
    return -1;
  endfunction

  task automatic expectSlot(input string req, input int s);
    chk(intReq == 1'b1 && intEmu == 1'b0, req, "offer", {30'd0, intEmu, intReq}, 32'h1);
    chk(intSlot == 4'(s), req, "slot", 32'(intSlot), 32'(s));
    chk(intVector == expVec(4'(s), noBootExt), req, "vector", 32'(intVector),
        32'(expVec(4'(s), noBootExt)));
  endtask

  task automatic pulseCore(input logic [3:0] v);
    coreReq = v; step(); coreReq = '0; step();
  endtask

  task automatic pulsePer(input logic [NP-1:0] v);
    periphReq = v; step(); periphReq = '0; step();
  endtask

  task automatic writeMask(input logic [15:0] v);
    maskWrEn = 1'b1; maskWrData = v; step(); maskWrEn = 1'b0;
  endtask

  task automatic writePrio(input int id, input logic [3:0] v);
    prioWrEn = 1'b1; prioWrId = 3'(id); prioWrVal = v; step(); prioWrEn = 1'b0;
  endtask

  task automatic ackRelease();
    intAck = 1'b1; step(); intAck = 1'b0; step();
  endtask

  task automatic endService();
    svcDone = 1'b1; step(); svcDone = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; emuReq = 0; coreReq = '0; periphReq = '0; prioWrEn = 0;
    prioWrId = '0; prioWrVal = '0; maskWrEn = 0; maskWrData = '0;
    globalEn = 0; noBootExt = 0; intAck = 0; svcDone = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();

    // R1 reset state
    chk(latchOut == 16'h0, "R1", "pending", 32'(latchOut), 32'h0);
    chk(maskOut == 16'h0, "R1", "enable", 32'(maskOut), 32'h0);
    chk(intReq == 1'b0, "R1", "offer", 32'(intReq), 32'h0);

    // R2 / R10: edge sets pending, disabled bit not offered
    pulseCore(4'b0010);
    chk(latchOut == 16'h0002, "R2", "pending", 32'(latchOut), 32'h2);
    chk(intReq == 1'b0, "R10", "masked offer", 32'(intReq), 32'h0);
    coreReq[2] = 1'b1; step();
    chk(latchOut == 16'h0006, "R2", "pending", 32'(latchOut), 32'h6);
    writeMask(16'hFFFF);
    chk(maskOut == 16'hFFFF, "R10", "enable", 32'(maskOut), 32'hFFFF);
    globalEn = 1'b1; step();
    expectSlot("R5", 1);
    noBootExt = 1'b1; step();
    expectSlot("R6", 1);

    // R8 acknowledge
    intAck = 1'b1; step();
    chk(intReq == 1'b0, "R8", "withdrawn", 32'(intReq), 32'h0);
    chk(latchOut == 16'h0004, "R8", "cleared", 32'(latchOut), 32'h4);
    noBootExt = 1'b0; step();
    chk(intVector == 24'h010020, "R8", "held vector", 32'(intVector), 32'h10020);
    intAck = 1'b0; step();
    chk(intReq == 1'b0, "R9", "lower blocked", 32'(intReq), 32'h0);
    endService();
    expectSlot("R9", 2);
    ackRelease(); endService();
    chk(latchOut == 16'h0000, "R2", "level no re-set", 32'(latchOut), 32'h0);
    coreReq = '0; step();

    // R3 peripheral mapping with reset default slot 3 (R1)
    pulsePer(8'h08);
    chk(latchOut == 16'h0080, "R3", "periph 3 default", 32'(latchOut), 32'h80);
    expectSlot("R6", 7);
    ackRelease(); endService();
    writePrio(3, 4'd13);
    pulsePer(8'h08);
    chk(latchOut == 16'h0000, "R3", "out of range", 32'(latchOut), 32'h0);
    chk(intReq == 1'b0, "R3", "no offer", 32'(intReq), 32'h0);

    // R4 remap and sharing
    writePrio(5, 4'd11); writePrio(6, 4'd11);
    pulsePer(8'h60);
    chk(latchOut == 16'h8000, "R4", "shared slot", 32'(latchOut), 32'h8000);
    expectSlot("R6", 15);
    ackRelease(); endService();
    chk(latchOut == 16'h0000, "R8", "cleared", 32'(latchOut), 32'h0);

    // R5 global enable gate
    globalEn = 1'b0;
    pulseCore(4'b1000);
    chk(intReq == 1'b0, "R5", "gated", 32'(intReq), 32'h0);
    pulseCore(4'b0001);
    expectSlot("R5", 0);
    ackRelease(); endService();

    // R7 emulator
    writeMask(16'h0000);
    emuReq = 1'b1; step(); emuReq = 1'b0; step();
    chk(intReq && intEmu, "R7", "emu offer", {30'd0, intEmu, intReq}, 32'h3);
    chk(intVector == 24'h0, "R7", "emu vector", 32'(intVector), 32'h0);
    ackRelease();
    chk(intReq == 1'b0, "R7", "emu taken", 32'(intReq), 32'h0);
    writeMask(16'hFFFF); globalEn = 1'b1; step();
    chk(intReq == 1'b0, "R9", "emu in service", 32'(intReq), 32'h0);
    endService();
    expectSlot("R9", 3);
    emuReq = 1'b1; step(); emuReq = 1'b0; step();
    chk(intReq && intEmu, "R7", "emu preempts", {30'd0, intEmu, intReq}, 32'h3);
    ackRelease(); endService();
    expectSlot("R7", 3);
    ackRelease(); endService();
    chk(latchOut == 16'h0000, "R8", "drained", 32'(latchOut), 32'h0);

    // Random phase against the model
    mLatch = '0; mMask = 16'hFFFF;
    for (int i = 0; i < NP; i++) mPrio[i] = 4'(i);
    mPrio[3] = 4'd13; mPrio[5] = 4'd11; mPrio[6] = 4'd11;
    for (int it = 0; it < 300; it++) begin
      logic [3:0] cs;
      logic [NP-1:0] ps;
      int pick;
      mMask = 16'($urandom);
      writeMask(mMask);
      globalEn = 1'($urandom);
      noBootExt = 1'($urandom);
      if ($urandom % 4 == 0) begin
        int id;
        logic [3:0] v;
        id = int'($urandom % NP);
        v = 4'($urandom);
        writePrio(id, v);
        mPrio[id] = v;
      end
      cs = 4'($urandom) & 4'($urandom);
      ps = NP'($urandom) & NP'($urandom);
      coreReq = cs; periphReq = ps; step();
      coreReq = '0; periphReq = '0; step();
      mLatch[3:0] = mLatch[3:0] | cs;
      for (int p = 0; p < NP; p++)
        if (ps[p] && mPrio[p] < 4'd12) mLatch[4 + int'(mPrio[p])] = 1'b1;
      chk(latchOut == mLatch, "R3", "random pending", 32'(latchOut), 32'(mLatch));
      pick = expPick(mLatch, mMask, globalEn);
      if (pick < 0) begin
        chk(intReq == 1'b0, "R5", "random idle", 32'(intReq), 32'h0);
      end else begin
        logic [23:0] v0;
        expectSlot("R5", pick);
        if ($urandom % 2 == 0) begin
          v0 = intVector;
          intAck = 1'b1; step();
          mLatch[pick] = 1'b0;
          chk(intReq == 1'b0 && intVector == v0, "R8", "random hold",
              32'(intVector), 32'(v0));
          intAck = 1'b0; svcDone = 1'b1; step(); svcDone = 1'b0;
        end
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule